// File: doc/BRIEF.md
# Microcontroller Interrupt Flag Controller

This block gathers the interrupt sources of a small 8-bit microcontroller core. There are four of them: an edge on an external request pin, with the polarity set by software; a change on any masked general-purpose input; a one-cycle timer-wrap strobe; and a one-cycle ADC completion strobe. Each source sets a flag bit. The flag stays set until software writes it to 0. Each flag has its own enable bit.

The enabled, pending flags are combined into one branch request. That request is gated by a global enable and captured only when the core signals phase Q1 of its four-phase instruction cycle. When the core accepts the request, the global enable drops by itself. While the core sleeps, any enabled pending flag raises a wake signal, whatever the global enable holds. The branch target is a fixed vector address.

Software reaches the block through a simple register port. The port gives access to a control/flag word, an edge-select word, a per-pin change mask, a peripheral enable word, a peripheral flag word and the synchronized input port. Reading that input port also loads the reference value that change detection compares against.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 except the edge-select word at address 5, which reads 8'h40 (rising edge). At reset `irq_req` and `wake` are 0.
- R2: Address 5 bit 6 selects the external pin edge: 1 = rising, 0 = falling. A matching edge sets control bit 1 on the third rising clock after the pin changes, and an edge of the other polarity leaves it clear.
- R3: A `tmr_wrap` pulse sets control bit 2 on the next clock. An `adc_done` pulse sets bit 6 of the peripheral flag word (address 3) on the next clock.
- R4: Control bit 0 is set while the synchronized inputs differ from the reference value in any bit that is set in the change mask (address 1). Unmasked bits have no effect. A register read of address 4 returns the synchronized inputs and loads them into the reference.
- R5: A flag changes only through its source or a register write of that bit. Clearing an enable bit leaves its flag unchanged.
- R6: If a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.
- R7: `irq_req` changes only on clocks where `phase_q1` is 1. On those clocks it loads global enable (control bit 7) AND the OR of flag AND enable over the timer (bits 5/2), pin (4/1), change (3/0) and ADC (address 2 bit 6 / address 3 bit 6) sources.
- R8: A `vec_ack` pulse clears the global enable and `irq_req` on the next clock, even if a register write in the same cycle tries to set the global enable.
- R9: `wake` is 1 exactly while `sleeping` is 1 and some flag is pending with its enable set, whatever the global enable holds.
- R10: `vec_addr` always presents the vector address 13'h0004.
- R11: Unimplemented bits read 0: control bit 6, the mask above its width, every peripheral bit but 6, and addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| phase_q1 | input | 1 | High during the Q1 phase of an instruction cycle |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| gp_in | input | GPW | General-purpose inputs (asynchronous) |
| tmr_wrap | input | 1 | Timer wrapped from FF to 00 |
| adc_done | input | 1 | ADC conversion finished |
| sleeping | input | 1 | Core is in sleep |
| vec_ack | input | 1 | Core is taking the vector |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_req | output | 1 | Branch request sampled at Q1 |
| wake | output | 1 | Wake request to a sleeping core |
| vec_addr | output | 13 | Interrupt vector address |

## Verification
The bench counts clocks from an external pin change to its flag. A synchronizer stage that is missing or doubled therefore shows up as a flag arriving one clock early or late. It tries edges of the wrong polarity, which a design with inverted edge select would latch. It collides a timer set with a software clear, where clear-wins logic loses the event. It leaves a masked input changed while clearing the change flag, then reads the port. A design that misses the reference reload either sticks at 1 or clears too early. It also checks that `irq_req` waits for the Q1 strobe, and that `wake` rises with the global enable off.

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl #(
  parameter int GPW = 6,
  parameter logic [12:0] VEC_ADDR = 13'h0004
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           phase_q1,
  input  logic           ext_pin,
  input  logic [GPW-1:0] gp_in,
  input  logic           tmr_wrap,
  input  logic           adc_done,
  input  logic           sleeping,
  input  logic           vec_ack,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [2:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic           irq_req,
  output logic           wake,
  output logic [12:0]    vec_addr
);
  localparam logic [2:0] A_CTL = 3'd0, A_MASK = 3'd1, A_PEN = 3'd2,
                         A_PFL = 3'd3, A_PORT = 3'd4, A_EDGE = 3'd5;

  logic gie, tmr_en, pin_en, chg_en, tmr_fl, pin_fl, chg_fl;
  logic adc_en, adc_fl, edge_rise;
  logic [GPW-1:0] mask, gp_s1, gp_s2, gp_ref;
  logic pin_s1, pin_s2, pin_prev;

  wire wr_ctl  = wr_en && addr == A_CTL;
  wire wr_pfl  = wr_en && addr == A_PFL;
  wire pin_hit = edge_rise ? (pin_s2 & ~pin_prev) : (~pin_s2 & pin_prev);
  wire chg_hit = |((gp_s2 ^ gp_ref) & mask);
  wire pending = (tmr_fl & tmr_en) | (pin_fl & pin_en) |
                 (chg_fl & chg_en) | (adc_fl & adc_en);

  assign wake     = sleeping & pending;
  assign vec_addr = VEC_ADDR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_s1 <= 1'b0; pin_s2 <= 1'b0; pin_prev <= 1'b0;
      gp_s1 <= '0; gp_s2 <= '0; gp_ref <= '0;
    end else begin
      pin_s1 <= ext_pin; pin_s2 <= pin_s1; pin_prev <= pin_s2;
      gp_s1 <= gp_in; gp_s2 <= gp_s1;
      if (rd_en && addr == A_PORT) gp_ref <= gp_s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gie <= 1'b0; tmr_en <= 1'b0; pin_en <= 1'b0; chg_en <= 1'b0;
      tmr_fl <= 1'b0; pin_fl <= 1'b0; chg_fl <= 1'b0;
      adc_en <= 1'b0; adc_fl <= 1'b0; edge_rise <= 1'b1; mask <= '0;
    end else begin
      if (vec_ack)     gie <= 1'b0;
      else if (wr_ctl) gie <= wdata[7];
      if (wr_ctl) begin
        tmr_en <= wdata[5]; pin_en <= wdata[4]; chg_en <= wdata[3];
      end
      tmr_fl <= tmr_wrap | (wr_ctl ? wdata[2] : tmr_fl);
      pin_fl <= pin_hit  | (wr_ctl ? wdata[1] : pin_fl);
      chg_fl <= chg_hit  | (wr_ctl ? wdata[0] : chg_fl);
      adc_fl <= adc_done | (wr_pfl ? wdata[6] : adc_fl);
      if (wr_en && addr == A_PEN)  adc_en    <= wdata[6];
      if (wr_en && addr == A_EDGE) edge_rise <= wdata[6];
      if (wr_en && addr == A_MASK) mask      <= wdata[GPW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        irq_req <= 1'b0;
    else if (vec_ack)  irq_req <= 1'b0;
    else if (phase_q1) irq_req <= gie & pending;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL:  rdata = {gie, 1'b0, tmr_en, pin_en, chg_en, tmr_fl, pin_fl, chg_fl};
      A_MASK: rdata[GPW-1:0] = mask;
      A_PEN:  rdata[6] = adc_en;
      A_PFL:  rdata[6] = adc_fl;
      A_PORT: rdata[GPW-1:0] = gp_s2;
      A_EDGE: rdata[6] = edge_rise;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mcu_irq_ctrl_chk.sv
module mcu_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_q1,
  input logic       vec_ack,
  input logic       sleeping,
  input logic       wake,
  input logic       irq_req,
  input logic       tmr_wrap,
  input logic       adc_done,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic       tmr_fl,
  input logic       adc_fl,
  input logic       gie
);
  // R3
  adc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> adc_fl);
  // R6
  tmr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> tmr_fl);
  // R5
  tmr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_fl && !(wr_en && addr == 3'd0)) |=> tmr_fl);
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_q1 && !vec_ack) |=> $stable(irq_req));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> (!gie && !irq_req));
  // R9
  no_wake_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleeping |-> !wake);
endmodule

bind mcu_irq_ctrl mcu_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_q1(phase_q1), .vec_ack(vec_ack),
  .sleeping(sleeping), .wake(wake), .irq_req(irq_req), .tmr_wrap(tmr_wrap),
  .adc_done(adc_done), .wr_en(wr_en), .addr(addr), .tmr_fl(tmr_fl),
  .adc_fl(adc_fl), .gie(gie)
);

// File: tb/mcu_irq_ctrl_tb.sv
`timescale 1ns/1ps
module mcu_irq_ctrl_tb;
  localparam int GPW = 6;
  logic clk = 0, rst_n = 0, phase_q1 = 0, ext_pin = 0, tmr_wrap = 0, adc_done = 0;
  logic sleeping = 0, vec_ack = 0, wr_en = 0, rd_en = 0;
  logic [GPW-1:0] gp_in = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq_req, wake;
  logic [12:0] vec_addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mcu_irq_ctrl #(.GPW(GPW)) u_dut (.*);

  // {addr, write data, expected read}
  localparam logic [18:0] VEC [9] = '{
    {3'd1, 8'hFF, 8'h3F}, {3'd2, 8'hFF, 8'h40}, {3'd5, 8'h00, 8'h00},
    {3'd5, 8'hFF, 8'h40}, {3'd0, 8'h78, 8'h38}, {3'd3, 8'h00, 8'h00},
    {3'd2, 8'h00, 8'h00}, {3'd1, 8'h00, 8'h00}, {3'd0, 8'h00, 8'h00}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk); addr = a; rd_en = 1; #1 chk(tag, rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1 irq_req", irq_req, 0); chk("R1 wake", wake, 0);
    rst_n = 1;
    rd(3'd0, "R1 ctl", 8'h00); rd(3'd5, "R1 edge", 8'h40);
    rd(3'd3, "R1 pflag", 8'h00);
    chk("R10 vec_addr", vec_addr, 13'h0004);
    // R11 register map walk
    foreach (VEC[i]) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], "R11 readback", VEC[i][7:0]);
    end
    rd(3'd6, "R11 addr6", 8'h00);

    // R2 rising edge, three-clock latency
    @(negedge clk); addr = 3'd0; ext_pin = 1;
    idle(2); #1 chk("R2 early", rdata[1], 0);
    idle(1); #1 chk("R2 rising", rdata[1], 1);
    wr(3'd0, 8'h00);
    @(negedge clk); ext_pin = 0; idle(5);
    rd(3'd0, "R2 falling ignored", 8'h00);
    wr(3'd5, 8'h00);
    @(negedge clk); ext_pin = 1; idle(5);
    rd(3'd0, "R2 rising ignored", 8'h00);
    @(negedge clk); ext_pin = 0; idle(5);
    rd(3'd0, "R2 falling", 8'h02);

    // R5 enable clear keeps flag
    wr(3'd0, 8'h12); wr(3'd0, 8'h02); idle(3);
    rd(3'd0, "R5 sticky", 8'h02);

    // R9 wake without global enable
    sleeping = 1; #1 chk("R9 disabled", wake, 0);
    wr(3'd0, 8'h12); #1 chk("R9 wake", wake, 1);
    sleeping = 0; #1 chk("R9 awake", wake, 0);

    // R7 Q1 sampling
    wr(3'd0, 8'h92); idle(2); chk("R7 wait q1", irq_req, 0);
    @(negedge clk); phase_q1 = 1; @(negedge clk); phase_q1 = 0;
    chk("R7 q1", irq_req, 1);
    // R8 ack
    @(negedge clk); vec_ack = 1; @(negedge clk); vec_ack = 0;
    chk("R8 irq", irq_req, 0);
    rd(3'd0, "R8 gie cleared", 8'h12);
    wr(3'd0, 8'h00);

    // R3 sources
    @(negedge clk); tmr_wrap = 1; @(negedge clk); tmr_wrap = 0;
    rd(3'd0, "R3 timer", 8'h04);
    @(negedge clk); adc_done = 1; @(negedge clk); adc_done = 0;
    rd(3'd3, "R3 adc", 8'h40);
    wr(3'd2, 8'h40); wr(3'd0, 8'h80);
    @(negedge clk); phase_q1 = 1; @(negedge clk); phase_q1 = 0;
    chk("R7 adc request", irq_req, 1);
    @(negedge clk); vec_ack = 1; @(negedge clk); vec_ack = 0;
    wr(3'd3, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h00);

    // R6 set wins over clear
    @(negedge clk); addr = 3'd0; wdata = 8'h00; wr_en = 1; tmr_wrap = 1;
    @(negedge clk); wr_en = 0; tmr_wrap = 0;
    rd(3'd0, "R6 set wins", 8'h04);
    wr(3'd0, 8'h00);

    // R4 pin change
    wr(3'd1, 8'h01);
    @(negedge clk); gp_in = 6'h02; idle(4);
    rd(3'd0, "R4 unmasked", 8'h00);
    @(negedge clk); gp_in = 6'h03; idle(4);
    rd(3'd0, "R4 masked", 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd0, "R4 mismatch holds", 8'h01);
    rd(3'd4, "R4 port", 8'h03);
    wr(3'd0, 8'h00); idle(2);
    rd(3'd0, "R4 cleared", 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule